// File: doc/BRIEF.md
# Ten-Source Level Interrupt Controller

This block collects ten level-sensitive interrupt request lines and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. Software reaches it through a small 32-bit register port made of a write strobe, a byte address and write data, with read data decoded at once from the address. Through this port software enables or disables each source. It steers each source to either output, and it can flip the active level of the two general-purpose external lines. A test register can replace the live request lines as the source of the raw status.

A request is pending for as long as its line is at its active level. Nothing is latched, so removing the request removes the interrupt. Both outputs are registered. Alongside them the block gives the number of the highest-numbered source that is pending on the normal line, with a flag that is low when no source is pending there. An interrupt entry that finds the flag low can be treated as spurious.

The register port is plain control access with no handshake. A write completes on the clock edge where `bus_we` is high. Read data is valid in the same cycle the address is presented, so there is no back-pressure to manage.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, steering, polarity, test-value and test-select registers are all zero, every register reads zero while all requests are low, and `irq_o`, `fiq_o` and `pend_valid_o` are low.
- R2: A write to byte offset 0x08 sets the enable bit of each source whose data bit is 1 and leaves the others unchanged. Reading 0x08 returns the current enables in bits 9:0.
- R3: A write to offset 0x0C clears the enable bit of each source whose data bit is 1 and leaves the others unchanged. Offset 0x0C reads zero.
- R4: Offset 0x04 returns the raw status, bit i for source i. With test select off, this is each request line after polarity correction, and it follows the line level in the same cycle with no latching.
- R5: Offset 0x00 returns the raw status ANDed with the enables.
- R6: The steering register at 0x14 sends source i to the fast output when bit i is 1 and to the normal output when it is 0. Offset 0x18 returns the masked status ANDed with the steering bits. One clock edge after the status is present, `fiq_o` is the OR of the fast-steered masked bits and `irq_o` is the OR of the normal-steered ones.
- R7: The polarity register at 0x24 uses 1 to mean active low, and it keeps only bits 4 and 5. Writes to its other bits are dropped, and those bits read back as zero.
- R8: When bit 0 of the test-select register at 0x20 is 1, the raw status equals the test-value register at 0x1C instead of the request lines. 0x20 reads back that single bit.
- R9: One edge after the status is present, `pend_idx_o` holds the highest index among the normal-steered masked sources, and `pend_valid_o` is high exactly when there is at least one such source. So `pend_valid_o` always equals `irq_o`.
- R10: Offsets 0x10, 0x28 to 0x3C and any offset not listed above read zero. Writes to them, or to the read-only offsets 0x00, 0x04 and 0x18, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | Level request lines, bit i for source i |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |
| pend_idx_o | output | 4 | Highest pending normal-steered source |
| pend_valid_o | output | 1 | High when `pend_idx_o` is meaningful |

## Verification
Two functions can act in the same cycle: a write that clears a source's enable, and the arrival of that source's request. The bench raises a request on one source and, in the same cycle, writes the clear register for that source. The normal output must rise for one cycle, because it was sampled with the old enable, and must then fall. The pending index must name that source during the high cycle. The sweeps also drive every one of the 1024 request patterns under four steering, polarity and test-source configurations. This makes fast and normal sources pending together in every combination, and each status read and output is compared against values computed from the requirements.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  // word index (byte offset >> 2) of each register
  localparam logic [3:0] W_MASKED = 4'h0;
  localparam logic [3:0] W_RAW    = 4'h1;
  localparam logic [3:0] W_EN_SET = 4'h2;
  localparam logic [3:0] W_EN_CLR = 4'h3;
  localparam logic [3:0] W_STEER  = 4'h5;
  localparam logic [3:0] W_FAST   = 4'h6;
  localparam logic [3:0] W_TVAL   = 4'h7;
  localparam logic [3:0] W_TSEL   = 4'h8;
  localparam logic [3:0] W_POL    = 4'h9;
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 10,
  parameter logic [NSRC-1:0] POL_MASK = 10'h030
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      widx,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] mode_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] tval_q,
  output logic            tsel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      tval_q <= '0;
      tsel_q <= 1'b0;
    end else if (wr_en) begin
      case (widx)
        W_EN_SET: en_q   <= en_q | wdata;
        W_EN_CLR: en_q   <= en_q & ~wdata;
        W_STEER:  mode_q <= wdata;
        W_TVAL:   tval_q <= wdata;
        W_TSEL:   tsel_q <= wdata[0];
        W_POL:    pol_q  <= wdata & POL_MASK;
        default:  ;
      endcase
    end
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata)));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_EN_CLR) |=> ((en_q & $past(wdata)) == '0));

  assert_pol_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q & ~POL_MASK) == '0);

  // R10: writes to read-only or unmapped words leave every register alone
  assert_ro_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (widx == W_MASKED || widx == W_RAW || widx == W_FAST ||
               widx == 4'h4 || widx > W_POL))
    |=> ($stable(en_q) && $stable(mode_q) && $stable(pol_q) &&
         $stable(tval_q) && $stable(tsel_q)));
endmodule

// File: rtl/irqc_srcpath.sv
`timescale 1ns/1ps
module irqc_srcpath #(
  parameter int unsigned NSRC = 10,
  parameter logic [NSRC-1:0] POL_MASK = 10'h030
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] tval,
  input  logic            tsel,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] mode,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] masked,
  output logic [NSRC-1:0] fast_vec,
  output logic [NSRC-1:0] norm_vec
);
  logic [NSRC-1:0] live;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (POL_MASK[i]) begin : g_inv
      assign live[i] = req[i] ^ pol[i];
    end else begin : g_fix
      assign live[i] = req[i];
    end
  end

  assign raw      = tsel ? tval : live;
  assign masked   = raw & en;
  assign fast_vec = masked & mode;
  assign norm_vec = masked & ~mode;
endmodule

// File: rtl/irqc_prienc.sv
`timescale 1ns/1ps
module irqc_prienc #(
  parameter int unsigned NSRC  = 10,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  vec,
  output logic [IDX_W-1:0] idx_q,
  output logic             valid_q
);
  logic [IDX_W-1:0] idx_d;
  logic             valid_d;

  always_comb begin
    idx_d   = '0;
    valid_d = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (vec[i]) begin
        idx_d   = i[IDX_W-1:0];
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (32'(idx_q) < NSRC));
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 10,
  parameter int unsigned ADDR_W = 6,
  parameter logic [NSRC-1:0] POL_MASK = 10'h030,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              pend_valid_o
);
  logic [NSRC-1:0] en_q, mode_q, pol_q, tval_q;
  logic            tsel_q;
  logic [NSRC-1:0] raw, masked, fast_vec, norm_vec;
  logic [3:0]      widx;
  logic            hit, wr_en;
  logic            unused_bits;

  assign widx  = bus_addr[5:2];
  assign hit   = (bus_addr >> 6) == '0;
  assign wr_en = bus_we & hit;
  assign unused_bits = ^{bus_wdata[31:NSRC], bus_addr[1:0]};

  irqc_regs #(.NSRC(NSRC), .POL_MASK(POL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx),
    .wdata(bus_wdata[NSRC-1:0]), .en_q(en_q), .mode_q(mode_q),
    .pol_q(pol_q), .tval_q(tval_q), .tsel_q(tsel_q));

  irqc_srcpath #(.NSRC(NSRC), .POL_MASK(POL_MASK)) u_src (
    .req(req_i), .pol(pol_q), .tval(tval_q), .tsel(tsel_q), .en(en_q),
    .mode(mode_q), .raw(raw), .masked(masked), .fast_vec(fast_vec),
    .norm_vec(norm_vec));

  irqc_prienc #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .vec(norm_vec),
    .idx_q(pend_idx_o), .valid_q(pend_valid_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |norm_vec;
      fiq_o <= |fast_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (widx)
        W_MASKED: bus_rdata = 32'(masked);
        W_RAW:    bus_rdata = 32'(raw);
        W_EN_SET: bus_rdata = 32'(en_q);
        W_STEER:  bus_rdata = 32'(mode_q);
        W_FAST:   bus_rdata = 32'(fast_vec);
        W_TVAL:   bus_rdata = 32'(tval_q);
        W_TSEL:   bus_rdata = 32'(tsel_q);
        W_POL:    bus_rdata = 32'(pol_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R9: encoder flag and the normal output come from separate flops
  assert_valid_tracks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == irq_o);

  // R6: a steered source never raises both outputs from a single bit
  assert_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_vec & norm_vec) == '0);
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  localparam int NSRC = 10;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  req_i;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, pend_valid_o;
  logic [3:0]  pend_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .pend_idx_o(pend_idx_o),
    .pend_valid_o(pend_valid_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one configuration, all 1024 patterns; sel mode drives the test register
  task automatic sweep(input logic [9:0] en, input logic [9:0] mode,
                       input logic [9:0] polw, input logic sel);
    logic [31:0] v;
    logic [9:0]  pol, reqv, eraw, em, ef, ei;
    logic [3:0]  eidx;
    pol = polw & 10'h030;
    wr(6'h0C, 32'h3FF);
    wr(6'h08, 32'(en));
    wr(6'h14, 32'(mode));
    wr(6'h24, 32'(polw));
    wr(6'h20, 32'(sel));
    for (int p = 0; p < 1024; p++) begin
      @(negedge clk);
      reqv = sel ? ~p[9:0] : p[9:0];
      req_i = reqv;
      if (sel) begin
        bus_we = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'(p);
      end
      @(negedge clk);
      bus_we = 1'b0;
      eraw = sel ? p[9:0] : (reqv ^ pol);
      em = eraw & en;
      ef = em & mode;
      ei = em & ~mode;
      eidx = '0;
      for (int b = 0; b < NSRC; b++) if (ei[b]) eidx = 4'(b);
      rd(6'h04, v); check(sel ? "R8 raw from test" : (pol != 0 ? "R7 raw polarity" : "R4 raw level"), v, 32'(eraw));
      rd(6'h00, v); check("R5 masked", v, 32'(em));
      rd(6'h18, v); check("R6 fast status", v, 32'(ef));
      @(negedge clk);
      check("R6 irq_o", 32'(irq_o), 32'(|ei));
      check("R6 fiq_o", 32'(fiq_o), 32'(|ef));
      check("R9 valid", 32'(pend_valid_o), 32'(|ei));
      if (|ei) check("R9 index", 32'(pend_idx_o), 32'(eidx));
    end
    req_i = '0;
    wr(6'h20, 32'h0);
    wr(6'h24, 32'h0);
  endtask

  initial begin
    #(4.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; req_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(6'(a * 4), v); check("R1 reset reg", v, 32'h0);
    end
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 valid", 32'(pend_valid_o), 0);

    // R2 / R3 write-one set and clear
    wr(6'h08, 32'h005); wr(6'h08, 32'hFFFF_F300);
    rd(6'h08, v); check("R2 enable set", v, 32'h305);
    wr(6'h0C, 32'h101);
    rd(6'h08, v); check("R3 enable clear", v, 32'h204);
    wr(6'h0C, 32'h0);
    rd(6'h08, v); check("R3 zero clear", v, 32'h204);
    rd(6'h0C, v); check("R3 clear reads zero", v, 32'h0);

    // R10 read-only and unmapped
    wr(6'h00, 32'h3FF); wr(6'h04, 32'h3FF); wr(6'h18, 32'h3FF);
    wr(6'h10, 32'h3FF); wr(6'h3C, 32'h3FF);
    rd(6'h08, v); check("R10 enable untouched", v, 32'h204);
    rd(6'h14, v); check("R10 steer untouched", v, 32'h0);
    rd(6'h1C, v); check("R10 test value untouched", v, 32'h0);
    rd(6'h24, v); check("R10 polarity untouched", v, 32'h0);
    rd(6'h20, v); check("R10 test select untouched", v, 32'h0);
    rd(6'h10, v); check("R10 unmapped 0x10", v, 32'h0);
    rd(6'h28, v); check("R10 unmapped 0x28", v, 32'h0);
    rd(6'h3C, v); check("R10 unmapped 0x3C", v, 32'h0);

    // R7 polarity mask
    wr(6'h24, 32'h3FF);
    rd(6'h24, v); check("R7 polarity readback", v, 32'h030);
    rd(6'h04, v); check("R7 idle low lines pending", v, 32'h030);
    wr(6'h24, 32'h0);

    // R8 test source
    wr(6'h1C, 32'h2A5); wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, v); check("R8 select readback", v, 32'h1);
    rd(6'h04, v); check("R8 raw from test", v, 32'h2A5);
    wr(6'h20, 32'h0);
    rd(6'h04, v); check("R8 select off", v, 32'h0);

    // same cycle: request arrives while its enable is being cleared (R3, R6, R9)
    wr(6'h0C, 32'h3FF); wr(6'h08, 32'h008);
    @(negedge clk);
    req_i = 10'h008; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h008;
    @(negedge clk);
    bus_we = 1'b0;
    check("R6 irq from old enable", 32'(irq_o), 1);
    check("R9 index during clear", 32'(pend_idx_o), 3);
    rd(6'h00, v); check("R3 masked after clear", v, 32'h0);
    @(negedge clk);
    check("R6 irq after clear", 32'(irq_o), 0);
    check("R9 valid after clear", 32'(pend_valid_o), 0);
    req_i = '0;

    // sweeps
    sweep(10'h3FF, 10'h000, 10'h000, 1'b0);
    sweep(10'h2B5, 10'h0F0, 10'h3FF, 1'b0);
    sweep(10'h2AA, 10'h3FF, 10'h010, 1'b0);
    sweep(10'h3FF, 10'h201, 10'h000, 1'b1);

    summary();
  end
endmodule